// File: doc/BRIEF.md
# Bus Performance Monitoring Counter Unit

This unit sits next to a memory or bus controller and measures its traffic. It has one free-running cycle counter and four event counters. Each event counter has a selection code. The code makes the counter tally read data beats, write data beats, or both. The beats arrive as single-cycle pulses on `rd_beat` and `wr_beat`.

Software drives the unit through a simple register port. A write is one cycle with `reg_wr` high. Read data is registered and appears one cycle after the address is presented. Through this port software starts and stops counting, clears counters, enables individual counters, picks events, reads counts and clears sticky overflow flags.

The last event counter is 8 bits wider than the others. It is read through two adjacent slots. Software rebuilds its value as `(high << 8) | low`.

Top module: `bpm_unit`

## Requirements
- R1: Bit 0 of the control register (offset 0x000) is the run flag, and it reads back. Writing it as 1 starts counting. Writing it as 0 stops all counting. While stopped, every counter holds its value.
- R2: A control write with bit 1 set clears the cycle counter and its overflow flag. A control write with bit 2 set clears all event counters and their overflow flags. A clear wins over an event or tick in the same cycle. Bits 1 and 2 read back as 0.
- R3: The enable-set register at 0x010 has bits 0..3 for event counters 0..3 and bit 31 for the cycle counter. Writing a 1 sets that enable. Writing a 0 leaves it unchanged. A read returns the current enables.
- R4: The cycle counter reads at 0x100. It advances by 1 each cycle while running with bit 31 enabled, and it wraps to 0.
- R5: The selection code for channel n sits at 0x1000 + 0x100·n in bits 2..0, and it reads back. The codes act as follows:
  - Code 5 counts read beats.
  - Code 6 counts write beats.
  - Code 7 counts both, and adds 2 when both beats arrive in the same cycle.
  - Every other code counts nothing.
- R6: Event counter n reads at 0x110 + 0x10·n. Counter 3 returns bits above 7 at 0x140 and bits 7..0 at 0x150.
- R7: The flag register at 0x050 has bit 31 for cycle-counter wrap and bits 0..3 for event-counter wraps. Each flag is sticky. Writing a 1 to a flag bit clears it. If a new wrap occurs in the same cycle as that write, the flag stays set.
- R8: Reads of unmapped offsets return 0. Read data appears on the cycle after the address.
- R9: Synchronous active-high reset zeroes all counters, enables, codes, flags, the run flag and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 16 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| rd_beat | input | 1 | One read data beat this cycle |
| wr_beat | input | 1 | One write data beat this cycle |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
A wrong run flag, enable bit or selection code shows as a count that drifts from the reference model. The drift appears on the first read of that counter after a single beat or tick. A lost or doubled increment for simultaneous beats shows up the same way. A flag that fails to stick, clear or set shows on the next read of offset 0x050. A mis-sliced wide counter appears only after its low byte has carried into the upper slot. To expose that case, the bench runs counter 3 past 255 and reads both slots.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int ADDR_W      = 16;
  localparam int NUM_EV      = 4;
  localparam int WIDE_IDX    = NUM_EV - 1;
  localparam int LOW_SLICE   = 8;
  localparam int OFF_CTRL    = 'h0000;
  localparam int OFF_ENSET   = 'h0010;
  localparam int OFF_FLAG    = 'h0050;
  localparam int OFF_CYC     = 'h0100;
  localparam int OFF_EVT0    = 'h0110;
  localparam int EVT_STRIDE  = 'h0010;
  localparam int OFF_SEL0    = 'h1000;
  localparam int SEL_STRIDE  = 'h0100;
  localparam int BIT_RUN     = 0;
  localparam int BIT_CLR_CYC = 1;
  localparam int BIT_CLR_EVT = 2;
  localparam int BIT_CYC     = 31;
  localparam logic [2:0] CODE_RD   = 3'd5;
  localparam logic [2:0] CODE_WR   = 3'd6;
  localparam logic [2:0] CODE_BOTH = 3'd7;
endpackage

// File: rtl/bpm_evt_counter.sv
module bpm_evt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic [2:0]   sel,
  input  logic         rd_beat,
  input  logic         wr_beat,
  output logic [W-1:0] count,
  output logic         wrap
);
  import bpm_pkg::*;
  logic [1:0] inc;
  logic [W:0] sum;

  always_comb begin
    case (sel)
      CODE_RD:   inc = {1'b0, rd_beat};
      CODE_WR:   inc = {1'b0, wr_beat};
      CODE_BOTH: inc = {1'b0, rd_beat} + {1'b0, wr_beat};
      default:   inc = 2'd0;
    endcase
  end

  assign sum  = {1'b0, count} + {{(W-1){1'b0}}, inc};
  assign wrap = run && !clr && sum[W];

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (run)   count <= sum[W-1:0];
  end
endmodule

// File: rtl/bpm_cyc_counter.sv
module bpm_cyc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = run && !clr && (&count);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (run)   count <= count + 1'b1;
  end
endmodule

// File: rtl/bpm_readmux.sv
module bpm_readmux #(
  parameter int DATA_W = 32,
  parameter int CYC_W  = 32,
  parameter int WIDE_W = 40
) (
  input  logic [bpm_pkg::ADDR_W-1:0]                   addr,
  input  logic                                         run,
  input  logic [bpm_pkg::NUM_EV-1:0]                   en_ev,
  input  logic                                         en_cyc,
  input  logic [bpm_pkg::NUM_EV-1:0]                   fl_ev,
  input  logic                                         fl_cyc,
  input  logic [CYC_W-1:0]                             cyc,
  input  logic [bpm_pkg::NUM_EV-1:0][WIDE_W-1:0]       cnt,
  input  logic [bpm_pkg::NUM_EV-1:0][2:0]              sel,
  output logic [DATA_W-1:0]                            data
);
  import bpm_pkg::*;

  always_comb begin
    data = '0;
    if (addr == ADDR_W'(OFF_CTRL)) begin
      data[BIT_RUN] = run;
    end else if (addr == ADDR_W'(OFF_ENSET)) begin
      data[NUM_EV-1:0] = en_ev;
      data[BIT_CYC]    = en_cyc;
    end else if (addr == ADDR_W'(OFF_FLAG)) begin
      data[NUM_EV-1:0] = fl_ev;
      data[BIT_CYC]    = fl_cyc;
    end else if (addr == ADDR_W'(OFF_CYC)) begin
      data = DATA_W'(cyc);
    end else if (addr == ADDR_W'(OFF_EVT0 + (WIDE_IDX + 1) * EVT_STRIDE)) begin
      data = DATA_W'(cnt[WIDE_IDX][LOW_SLICE-1:0]);
    end
    for (int n = 0; n < NUM_EV; n++) begin
      if (addr == ADDR_W'(OFF_EVT0 + n * EVT_STRIDE)) begin
        if (n == WIDE_IDX) data = DATA_W'(cnt[n] >> LOW_SLICE);
        else               data = DATA_W'(cnt[n]);
      end
      if (addr == ADDR_W'(OFF_SEL0 + n * SEL_STRIDE))
        data = DATA_W'(sel[n]);
    end
  end
endmodule

// File: rtl/bpm_unit.sv
module bpm_unit #(
  parameter int CNT_W  = 32,
  parameter int CYC_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic [bpm_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  input  logic                       rd_beat,
  input  logic                       wr_beat,
  output logic [DATA_W-1:0]          reg_rdata
);
  import bpm_pkg::*;
  localparam int WIDE_W = CNT_W + LOW_SLICE;

  logic                          run_q, en_cyc_q, fl_cyc_q;
  logic [NUM_EV-1:0]             en_ev_q, fl_ev_q, ev_wrap, w1c_ev;
  logic [NUM_EV-1:0][2:0]        sel_q;
  logic [NUM_EV-1:0][WIDE_W-1:0] cnt_ext;
  logic [CYC_W-1:0]              cyc_q;
  logic                          cyc_wrap;
  logic                          wr_ctrl, wr_enset, wr_flag, clr_cyc, clr_evt;
  logic [DATA_W-1:0]             rd_next;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
  assign wr_enset = reg_wr && (reg_addr == ADDR_W'(OFF_ENSET));
  assign wr_flag  = reg_wr && (reg_addr == ADDR_W'(OFF_FLAG));
  assign clr_cyc  = wr_ctrl && reg_wdata[BIT_CLR_CYC];
  assign clr_evt  = wr_ctrl && reg_wdata[BIT_CLR_EVT];
  assign w1c_ev   = wr_flag ? reg_wdata[NUM_EV-1:0] : '0;

  bpm_cyc_counter #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst(rst), .clr(clr_cyc), .run(run_q && en_cyc_q),
    .count(cyc_q), .wrap(cyc_wrap)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ch
    if (g == WIDE_IDX) begin : g_wide
      logic [WIDE_W-1:0] c;
      bpm_evt_counter #(.W(WIDE_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr_evt), .run(run_q && en_ev_q[g]),
        .sel(sel_q[g]), .rd_beat(rd_beat), .wr_beat(wr_beat),
        .count(c), .wrap(ev_wrap[g])
      );
      assign cnt_ext[g] = c;
    end else begin : g_norm
      logic [CNT_W-1:0] c;
      bpm_evt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr_evt), .run(run_q && en_ev_q[g]),
        .sel(sel_q[g]), .rd_beat(rd_beat), .wr_beat(wr_beat),
        .count(c), .wrap(ev_wrap[g])
      );
      assign cnt_ext[g] = WIDE_W'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      en_ev_q  <= '0;
      en_cyc_q <= 1'b0;
      sel_q    <= '0;
      fl_ev_q  <= '0;
      fl_cyc_q <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= reg_wdata[BIT_RUN];
      if (wr_enset) begin
        en_ev_q  <= en_ev_q | reg_wdata[NUM_EV-1:0];
        en_cyc_q <= en_cyc_q | reg_wdata[BIT_CYC];
      end
      for (int n = 0; n < NUM_EV; n++)
        if (reg_wr && reg_addr == ADDR_W'(OFF_SEL0 + n * SEL_STRIDE))
          sel_q[n] <= reg_wdata[2:0];
      fl_ev_q  <= (fl_ev_q & ~w1c_ev & ~{NUM_EV{clr_evt}}) | ev_wrap;
      fl_cyc_q <= (fl_cyc_q && !(wr_flag && reg_wdata[BIT_CYC]) && !clr_cyc) || cyc_wrap;
    end
  end

  bpm_readmux #(.DATA_W(DATA_W), .CYC_W(CYC_W), .WIDE_W(WIDE_W)) u_mux (
    .addr(reg_addr), .run(run_q), .en_ev(en_ev_q), .en_cyc(en_cyc_q),
    .fl_ev(fl_ev_q), .fl_cyc(fl_cyc_q), .cyc(cyc_q), .cnt(cnt_ext),
    .sel(sel_q), .data(rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/bpm_unit_checker.sv
module bpm_unit_checker #(
  parameter int CYC_W  = 32,
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       reg_wr,
  input logic [bpm_pkg::ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic                       run_q,
  input logic                       en_cyc_q,
  input logic [bpm_pkg::NUM_EV-1:0] en_ev_q,
  input logic [CYC_W-1:0]           cyc_q,
  input logic                       fl_cyc_q
);
  import bpm_pkg::*;
  logic ctl_w, flag_w;
  assign ctl_w  = reg_wr && reg_addr == ADDR_W'(OFF_CTRL);
  assign flag_w = reg_wr && reg_addr == ADDR_W'(OFF_FLAG);

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ctl_w) |=> $stable(cyc_q));

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && reg_wdata[BIT_CLR_CYC]) |=> (cyc_q == '0));

  assert_enable_kept_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((en_ev_q & $past(en_ev_q)) == $past(en_ev_q)));

  assert_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && en_cyc_q && !ctl_w) |=> ((cyc_q - $past(cyc_q)) == CYC_W'(1)));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (fl_cyc_q && !(flag_w && reg_wdata[BIT_CYC]) && !(ctl_w && reg_wdata[BIT_CLR_CYC]))
    |=> fl_cyc_q);
endmodule

bind bpm_unit bpm_unit_checker #(.CYC_W(CYC_W), .DATA_W(DATA_W)) u_bpm_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .run_q(run_q), .en_cyc_q(en_cyc_q),
  .en_ev_q(en_ev_q), .cyc_q(cyc_q), .fl_cyc_q(fl_cyc_q)
);

// File: tb/bpm_unit_bench.sv
module bpm_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int YW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rd_beat = 1'b0, wr_beat = 1'b0;
  logic [31:0] reg_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  bit        m_run, m_en_cyc, m_fl_cyc;
  bit [3:0]  m_en_ev, m_fl_ev;
  bit [2:0]  m_sel [4];
  int        m_cyc;
  int        m_cnt [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  bpm_unit #(.CNT_W(CW), .CYC_W(YW), .DATA_W(32)) u_bpm_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_beat(rd_beat), .wr_beat(wr_beat),
    .reg_rdata(reg_rdata)
  );

  function automatic int cmax(int n);
    return (n == 3) ? 65535 : 255;
  endfunction

  function automatic logic [31:0] mread(logic [15:0] a);
    if (a == 16'h0000) return {31'd0, m_run};
    if (a == 16'h0010) return {m_en_cyc, 27'd0, m_en_ev};
    if (a == 16'h0050) return {m_fl_cyc, 27'd0, m_fl_ev};
    if (a == 16'h0100) return 32'(m_cyc);
    if (a == 16'h0110) return 32'(m_cnt[0]);
    if (a == 16'h0120) return 32'(m_cnt[1]);
    if (a == 16'h0130) return 32'(m_cnt[2]);
    if (a == 16'h0140) return 32'(m_cnt[3] >> 8);
    if (a == 16'h0150) return 32'(m_cnt[3] & 255);
    for (int n = 0; n < 4; n++)
      if (a == 16'(16'h1000 + n * 16'h0100)) return {29'd0, m_sel[n]};
    return 32'd0;
  endfunction

  function automatic string tag_of(logic [15:0] a);
    if (a == 16'h0000) return "R1";
    if (a == 16'h0010) return "R3";
    if (a == 16'h0050) return "R7";
    if (a == 16'h0100) return "R4";
    if (a >= 16'h0110 && a <= 16'h0150 && a[3:0] == 4'h0) return "R6";
    if (a[15:12] == 4'h1 && a[7:0] == 8'h00 && a[11:8] < 4) return "R5";
    return "R8";
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(bit w, logic [15:0] a, logic [31:0] d, bit r, bit wb);
    bit clr_c, clr_e, wrap_c;
    bit [3:0] wrap_e, w1c;
    int inc, s;
    clr_c = w && a == 16'h0000 && d[1];
    clr_e = w && a == 16'h0000 && d[2];
    wrap_c = 0; wrap_e = '0;
    if (clr_c) m_cyc = 0;
    else if (m_run && m_en_cyc) begin
      if (m_cyc == 255) wrap_c = 1;
      m_cyc = (m_cyc + 1) & 255;
    end
    for (int n = 0; n < 4; n++) begin
      case (m_sel[n])
        3'd5: inc = int'(r);
        3'd6: inc = int'(wb);
        3'd7: inc = int'(r) + int'(wb);
        default: inc = 0;
      endcase
      if (clr_e) m_cnt[n] = 0;
      else if (m_run && m_en_ev[n]) begin
        s = m_cnt[n] + inc;
        if (s > cmax(n)) wrap_e[n] = 1;
        m_cnt[n] = s & cmax(n);
      end
    end
    w1c = (w && a == 16'h0050) ? d[3:0] : 4'd0;
    m_fl_ev  = (m_fl_ev & ~w1c & ~{4{clr_e}}) | wrap_e;
    m_fl_cyc = (m_fl_cyc && !(w && a == 16'h0050 && d[31]) && !clr_c) || wrap_c;
    if (w && a == 16'h0000) m_run = d[0];
    if (w && a == 16'h0010) begin
      m_en_ev  = m_en_ev | d[3:0];
      m_en_cyc = m_en_cyc | d[31];
    end
    for (int n = 0; n < 4; n++)
      if (w && a == 16'(16'h1000 + n * 16'h0100)) m_sel[n] = d[2:0];
  endtask

  // one cycle: drive, check registered read of address a
  task automatic step(bit w, logic [15:0] a, logic [31:0] d, bit r, bit wb, string tag = "");
    logic [31:0] exp;
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; rd_beat = r; wr_beat = wb;
    exp = mread(a);
    model_step(w, a, d, r, wb);
    @(posedge clk); #1;
    check(reg_rdata, exp, (tag == "") ? tag_of(a) : tag);
  endtask

  task automatic rd(logic [15:0] a, string tag = "");
    step(0, a, 32'd0, 0, 0, tag);
  endtask

  function automatic logic [15:0] pick_addr();
    int k = int'($urandom % 16);
    case (k)
      0: return 16'h0000; 1: return 16'h0010; 2: return 16'h0050;
      3: return 16'h0100; 4: return 16'h0110; 5: return 16'h0120;
      6: return 16'h0130; 7: return 16'h0140; 8: return 16'h0150;
      9: return 16'h1000; 10: return 16'h1100; 11: return 16'h1200;
      12: return 16'h1300; 13: return 16'h0004;
      14: return 16'h1400; default: return 16'h0160;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1: watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra;
    logic [31:0] rdat;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 check(reg_rdata, 32'd0, "R9");
    @(negedge clk); rst = 1'b0;
    // R9: every register reads zero after reset
    foreach (m_cnt[i]) m_cnt[i] = 0;
    rd(16'h0000, "R9"); rd(16'h0010, "R9"); rd(16'h0050, "R9");
    rd(16'h0100, "R9"); rd(16'h0140, "R9"); rd(16'h1300, "R9");

    // R5 codes and R3 enables
    step(1, 16'h1000, 32'h5, 0, 0);
    step(1, 16'h1100, 32'h6, 0, 0);
    step(1, 16'h1200, 32'h7, 0, 0);
    step(1, 16'h1300, 32'h7, 0, 0);
    step(1, 16'h0010, 32'h8000_0005, 0, 0);
    step(1, 16'h0010, 32'h0000_000A, 0, 0);
    rd(16'h0010, "R3");
    // R1: nothing counts before run
    step(0, 16'h0110, 0, 1, 1, "R1");
    step(0, 16'h0100, 0, 1, 1, "R1");
    step(1, 16'h0000, 32'h1, 0, 0);
    step(0, 16'h0110, 0, 1, 0);
    step(0, 16'h0120, 0, 0, 1);
    step(0, 16'h0130, 0, 1, 1, "R5");
    step(0, 16'h0130, 0, 1, 1, "R5");
    rd(16'h0130, "R5");
    rd(16'h0120, "R5");
    // R1: stop holds
    step(1, 16'h0000, 32'h0, 0, 0);
    step(0, 16'h0100, 0, 1, 1, "R1");
    step(0, 16'h0130, 0, 1, 1, "R1");
    rd(16'h0130, "R1");
    // R2: clear with run and simultaneous beats
    step(1, 16'h0000, 32'h7, 1, 1);
    rd(16'h0130, "R2");
    rd(16'h0000, "R2");
    // R7: cycle wrap and same-cycle clear attempt
    while (m_cyc != 255) rd(16'h0050);
    step(1, 16'h0050, 32'h8000_0000, 0, 0);
    rd(16'h0050, "R7");
    step(1, 16'h0050, 32'h8000_0000, 0, 0);
    rd(16'h0050, "R7");
    // R6: wide counter carries into upper slot
    repeat (140) step(0, 16'h0150, 0, 1, 1);
    rd(16'h0140, "R6"); rd(16'h0150, "R6"); rd(16'h0050, "R7");
    // R8: unmapped
    rd(16'h0004, "R8"); rd(16'h1004, "R8"); rd(16'h0200, "R8");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit w = ($urandom % 5) == 0;
      ra = pick_addr();
      rdat = $urandom;
      if (ra == 16'h0000)
        rdat = {29'd0, ($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 4) != 0};
      step(w, ra, rdat, $urandom % 2 == 1, $urandom % 2 == 1);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule